// File: doc/BRIEF.md
# Limit-Match Periodic Tick Timer

This block is a word-addressed counter/timer with a programmable match limit. A prescaler turns the core clock into a 500 ns tick; each tick advances a 22-bit count field that sits in bits 30..9 of the register word, so one tick adds 0x200 to the visible value. When a nonzero limit is programmed, the count restarts from zero each time it would reach the limit. A match sets a sticky reached flag and holds a level interrupt high until software clears it. A zero limit turns the block into a free-running counter that never flags.

Software uses four behaviours. Writing the limit word starts a fresh period. Writing the alternate limit word changes the period without disturbing the running count. Reading the counter word samples the count together with the reached flag. Reading the limit word acknowledges the interrupt.

The control is a three-state machine. ST_FREE means the limit is zero and no match is possible. ST_ARMED means the limit is nonzero and the flag is clear. ST_HIT means the flag is set and the interrupt is asserted. The transitions are as follows:
- A limit write moves the machine to ST_FREE or ST_ARMED, depending on whether the new limit is zero.
- A match moves the machine to ST_HIT.
- From ST_HIT, a limit read (the acknowledge) returns the machine to ST_FREE or ST_ARMED, chosen by the limit in force.
- In ST_FREE or ST_ARMED, a keep-count write moves the machine between those two states according to the new limit.
- In ST_HIT, a keep-count write leaves the flag set.

Top module: `lmt_timer`

## Requirements
- R1: The count field (bits 30..9) advances by one every TICK_DIV clock cycles, and bits 8..0 of every read word are zero.
- R2: A read of byte offset 0x4 returns {reached flag in bit 31, count in bits 30..9, 9'b0}. Read data appears on `bus_rdata` the cycle after `bus_rd` is high and holds until the next read.
- R3: A write to offset 0x0 sets the limit to `bus_wdata[30:9]` and discards all other bits. The same write restarts both the count and the prescale phase from zero.
- R4: A write to offset 0x0 clears the reached flag and drops `irq` on the next cycle. This holds even if a match falls on the same edge.
- R5: With a limit of zero the count runs freely, wrapping from field value 0x3FFFFF to 0. The reached flag and `irq` are never set in this mode.
- R6: With a nonzero limit L, the tick that would take the count to L instead returns it to 0, sets the reached flag and raises `irq`. This repeats every L ticks, and `irq` stays high across later matches until it is cleared.
- R7: A read of offset 0x0 returns {1'b0, limit, 9'b0}. In the cycle `bus_rd` is high, the read clears the reached flag and `irq`. A match on the same edge takes priority, and the flag stays set.
- R8: A write to offset 0x8 loads the limit from `bus_wdata[30:9]`. It leaves the count, the prescale phase and the reached flag untouched.
- R9: Writes to offsets 0x4, 0xC and 0x10 have no effect. Reads of every offset other than 0x0 and 0x4 return zero.
- R10: After reset the limit, count, reached flag and `irq` are all zero, and the block counts in free-run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 1..0 ignored |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while the reached flag is set |

## Verification
The hardest case to reach is a bus access that lands on exactly the edge where a match occurs. In that case the acknowledge read must lose to the match, while the limit write must win. A limit write restarts the prescaler, so the match edge falls a known L×TICK_DIV cycles after the write edge. The stimulus counts cycles from that write and places a limit read on that edge, and later a limit write on another such edge. A reference model in the bench follows every tick and reports any drift in count or flag through the next counter read.

// File: rtl/lmt_pkg.sv
package lmt_pkg;
    localparam int DATA_W  = 32;
    localparam int CNT_LSB = 9;
    localparam int CNT_W   = 22;

    // Word indices (byte offset >> 2); the decode depends on these values.
    localparam logic [2:0] WIX_LIMIT  = 3'd0;
    localparam logic [2:0] WIX_COUNT  = 3'd1;
    localparam logic [2:0] WIX_KEEP   = 3'd2;

    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HIT   = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic wr_lim;
        logic wr_keep;
        logic rd_lim;
    } tmr_ctl_s;
endpackage

// File: rtl/lmt_prescaler.sv
module lmt_prescaler #(
    parameter int TICK_DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] phase_q;
    logic [PW-1:0] phase_d;

    assign tick = (phase_q == LAST);

    always_comb begin
        if (restart || tick) phase_d = '0;
        else                 phase_d = phase_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end

    generate
        if (TICK_DIV > 1) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);                                   // R1
            AST_RESTART_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !tick);                                // R3
        end
    endgenerate
endmodule

// File: rtl/lmt_count_core.sv
module lmt_count_core
    import lmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmr_ctl_s         ctl,
    input  logic [CNT_W-1:0] wr_field,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] lim_o,
    output logic             reached_o,
    output logic             irq_o
);
    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim_q, lim_d;
    logic [CNT_W-1:0] cnt_inc;
    logic             match;
    logic             lim_next_nz;

    assign cnt_inc     = cnt_q + 1'b1;
    assign match       = tick && (lim_q != '0) && (cnt_inc == lim_q);
    assign lim_d       = (ctl.wr_lim || ctl.wr_keep) ? wr_field : lim_q;
    assign lim_next_nz = (lim_d != '0);

    // next-state
    always_comb begin
        state_d = state_q;
        if (ctl.wr_lim) begin
            state_d = lim_next_nz ? ST_ARMED : ST_FREE;
        end else if (match) begin
            state_d = ST_HIT;
        end else begin
            unique case (state_q)
                ST_FREE, ST_ARMED: begin
                    if (ctl.wr_keep) state_d = lim_next_nz ? ST_ARMED : ST_FREE;
                end
                ST_HIT: begin
                    if (ctl.rd_lim) state_d = lim_next_nz ? ST_ARMED : ST_FREE;
                end
                default: state_d = ST_FREE;
            endcase
        end
    end

    always_comb begin
        if (ctl.wr_lim)  cnt_d = '0;
        else if (tick)   cnt_d = match ? '0 : cnt_inc;
        else             cnt_d = cnt_q;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            cnt_q   <= '0;
            lim_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lim_q   <= lim_d;
        end
    end

    // outputs
    always_comb begin
        cnt_o     = cnt_q;
        lim_o     = lim_q;
        reached_o = (state_q == ST_HIT);
        irq_o     = (state_q == ST_HIT);
    end

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ctl.wr_lim) |=> $stable(cnt_q));                           // R1
    AST_LIMIT_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.wr_lim |=> (cnt_q == '0 && !irq_o));                              // R4
    AST_FREE_NEVER_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_q == '0 && state_q != ST_HIT && !ctl.wr_lim) |=> state_q != ST_HIT); // R5
    AST_FREE_STATE_ZERO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE) |-> (lim_q == '0));                              // R5
    AST_MATCH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !ctl.wr_lim) |=> (irq_o && cnt_q == '0));                   // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !ctl.wr_lim && !ctl.rd_lim) |=> irq_o);                     // R6
    AST_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.rd_lim && !match && !ctl.wr_lim) |=> !irq_o);                    // R7
    AST_KEEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.wr_keep && !ctl.wr_lim && !tick) |=> $stable(cnt_q));            // R8
endmodule

// File: rtl/lmt_regif.sv
module lmt_regif
    import lmt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  lim,
    input  logic              reached,
    output tmr_ctl_s          ctl,
    output logic [CNT_W-1:0]  wr_field,
    output logic [DATA_W-1:0] rdata
);
    localparam int IW = ADDR_W - 2;

    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;
    logic              unused_bits;

    assign idx         = bus_addr[ADDR_W-1:2];
    assign wr_field    = bus_wdata[CNT_LSB +: CNT_W];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1], bus_wdata[CNT_LSB-1:0]};

    always_comb begin
        ctl.wr_lim  = bus_wr && (idx == IW'(WIX_LIMIT));
        ctl.wr_keep = bus_wr && (idx == IW'(WIX_KEEP));
        ctl.rd_lim  = bus_rd && (idx == IW'(WIX_LIMIT));
    end

    always_comb begin
        rd_word = '0;
        if (idx == IW'(WIX_LIMIT))      rd_word = {1'b0, lim, {CNT_LSB{1'b0}}};
        else if (idx == IW'(WIX_COUNT)) rd_word = {reached, cnt, {CNT_LSB{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_word;
    end

    assign rdata = rdata_q;

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[CNT_LSB-1:0] == '0);                                             // R1
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && idx > IW'(WIX_COUNT)) |=> (rdata == '0));                   // R9
    AST_LIMIT_READ_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.rd_lim |=> !rdata[DATA_W-1]);                                      // R7
endmodule

// File: rtl/lmt_timer.sv
module lmt_timer
    import lmt_pkg::*;
#(
    parameter int TICK_DIV = 25,
    parameter int ADDR_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    tmr_ctl_s         ctl;
    logic [CNT_W-1:0] wr_field;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             reached;
    logic             tick;

    lmt_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (ctl.wr_lim),
        .tick    (tick)
    );

    lmt_count_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .ctl       (ctl),
        .wr_field  (wr_field),
        .cnt_o     (cnt),
        .lim_o     (lim),
        .reached_o (reached),
        .irq_o     (irq)
    );

    lmt_regif #(.ADDR_W(ADDR_W)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .cnt       (cnt),
        .lim       (lim),
        .reached   (reached),
        .ctl       (ctl),
        .wr_field  (wr_field),
        .rdata     (bus_rdata)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !irq);   // R10
endmodule

// File: tb/lmt_timer_tb_top.sv
`timescale 1ns/1ps
module lmt_timer_tb_top;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    always #10 clk = ~clk;

    lmt_timer #(.TICK_DIV(DIV), .ADDR_W(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct { logic [31:0] exp; string tag; } exp_t;
    exp_t  sb_q[$];
    string cur_tag = "R10";
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    // reference model, built from the requirements
    int          pc_m;
    logic [21:0] c_m, l_m, cp_m;
    logic        f_m, rd_dly, tk_m, mt_m;
    logic [2:0]  ix_m;
    exp_t        e_in, e_out;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            pc_m = 0; c_m = '0; l_m = '0; f_m = 1'b0; rd_dly = 1'b0;
        end else begin
            ix_m = bus_addr[4:2];
            if (bus_rd) begin
                e_in.tag = cur_tag;
                case (ix_m)
                    3'd0:    e_in.exp = {1'b0, l_m, 9'b0};
                    3'd1:    e_in.exp = {f_m, c_m, 9'b0};
                    default: e_in.exp = 32'h0;
                endcase
                sb_q.push_back(e_in);
            end
            rd_dly = bus_rd;
            tk_m = (pc_m == DIV - 1);
            cp_m = c_m + 22'd1;
            mt_m = tk_m && (l_m != 0) && (cp_m == l_m);
            if (bus_wr && ix_m == 3'd0) begin
                c_m = '0; pc_m = 0; l_m = bus_wdata[30:9]; f_m = 1'b0;
            end else begin
                pc_m = tk_m ? 0 : pc_m + 1;
                if (tk_m) c_m = mt_m ? 22'd0 : cp_m;
                if (bus_wr && ix_m == 3'd2) l_m = bus_wdata[30:9];
                if (mt_m) f_m = 1'b1;
                else if (bus_rd && ix_m == 3'd0) f_m = 1'b0;
            end
        end
    end

    // monitor: compare read data against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_dly) begin
            if (sb_q.size() == 0) chk(1'b0, "R2 scoreboard empty", bus_rdata, 32'h0);
            else begin
                e_out = sb_q.pop_front();
                chk(bus_rdata === e_out.exp, e_out.tag, bus_rdata, e_out.exp);
            end
        end
    end

    // driver tasks: called at a falling edge, return at a falling edge
    task automatic bwr(input logic [4:0] a, input logic [31:0] d, input string t);
        cur_tag = t; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask
    task automatic brd(input logic [4:0] a, input string t);
        cur_tag = t; bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic irq_is(input logic exp, input string t);
        chk(irq === exp, t, {31'b0, irq}, {31'b0, exp});
        chk(irq === f_m, {t, " model"}, {31'b0, irq}, {31'b0, f_m});
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        irq_is(1'b0, "R10 irq after reset");
        brd(5'h00, "R10 limit after reset");
        brd(5'h04, "R10 count after reset");

        idle(29);
        brd(5'h04, "R1 count after ticks");
        brd(5'h04, "R2 counter read");
        idle(100);
        irq_is(1'b0, "R5 free-run no irq");
        brd(5'h04, "R5 free-run count");

        bwr(5'h00, 32'h8000_07FF, "R3 limit write mask");
        brd(5'h00, "R3 limit readback");
        brd(5'h04, "R3 count restarted");
        idle(20);
        irq_is(1'b1, "R6 match raises irq");
        brd(5'h04, "R6 reached bit in count");
        idle(30);
        irq_is(1'b1, "R6 irq sticky over matches");
        brd(5'h00, "R7 limit read");
        irq_is(1'b0, "R7 read clears irq");

        // coincident limit read and match: match wins
        bwr(5'h00, 32'h0000_0600, "R4 restart period");
        irq_is(1'b0, "R4 irq low after write");
        idle(11);
        brd(5'h00, "R7 read on match edge");
        irq_is(1'b1, "R7 match beats read");
        // coincident limit write and match: write wins
        bwr(5'h00, 32'h0000_0600, "R4 restart period");
        idle(11);
        bwr(5'h00, 32'h0000_0600, "R4 write on match edge");
        irq_is(1'b0, "R4 write beats match");

        // ignored writes and zero reads
        bwr(5'h04, 32'h1234_5600, "R9 counter write");
        brd(5'h04, "R9 count unaffected");
        bwr(5'h0C, 32'hFFFF_FFFF, "R9 status write");
        bwr(5'h10, 32'hFFFF_FFFF, "R9 mode write");
        brd(5'h00, "R9 limit unaffected");
        brd(5'h08, "R9 keep offset reads zero");
        brd(5'h0C, "R9 status reads zero");
        brd(5'h10, "R9 mode reads zero");
        brd(5'h14, "R9 offset 0x14 zero");
        brd(5'h1C, "R9 offset 0x1C zero");

        // keep-count limit load
        bwr(5'h00, 32'd10 << 9, "R8 base limit");
        idle(21);
        bwr(5'h08, 32'd8 << 9, "R8 keep write");
        brd(5'h04, "R8 count not restarted");
        idle(10);
        irq_is(1'b1, "R8 match at new limit");
        brd(5'h00, "R8 new limit read");
        bwr(5'h00, 32'd20 << 9, "R8 base limit 2");
        idle(40);
        bwr(5'h08, 32'd4 << 9, "R8 limit below count");
        idle(40);
        irq_is(1'b0, "R8 no match below count");
        brd(5'h04, "R8 count keeps running");

        bwr(5'h00, 32'hFFFF_FFFF, "R3 full mask");
        brd(5'h00, "R3 full mask readback");
        bwr(5'h00, 32'h0, "R5 back to free-run");
        idle(60);
        irq_is(1'b0, "R5 free-run stays quiet");
        brd(5'h04, "R5 free-run count");
        idle(2);
        chk(sb_q.size() == 0, "R2 scoreboard drained", sb_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule